// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and a calendar in packed BCD: seconds, minutes, hours, day of the week, day of the month, month and a two-digit year. A built-in prescaler turns a stream of single-cycle tick pulses into one seconds event. The pulses come either from a crystal-derived source, counted in groups of a parameter (32 by default), or from a mains-frequency source counted in groups of 50 or 60. A run control holds the prescaler cleared and stops all counting while it is low.

Hours are kept in 24-hour form (00 to 23) or in 12-hour form (01 to 12) with a PM flag, as chosen by a mode input. February has 29 days when the year is a multiple of four, and year 00 counts as one. A host loads any field through a single-cycle write port, and all fields are always visible on parallel outputs. Writing the seconds field restarts the prescaler, so the next seconds event comes a full second after the write.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the outputs read seconds 0x00, minutes 0x00, hours 0x00, day of week 0x01, date 0x01, month 0x01 and year 0x00.
- R2: With run high and the crystal source selected (src_line low), the clock edge that accepts the XTAL_DIV-th high cycle of xtal_tick since the last seconds event or prescaler clear is a seconds event, and the new field values show after that edge.
- R3: With src_line high, seconds events come every 50 line_tick cycles when line_50 is high and every 60 when it is low, and xtal_tick has no effect.
- R4: While run is low the prescaler is held at zero and no field changes. After run rises, a full second's worth of ticks is needed before the next event.
- R5: Seconds and minutes count 00 to 59 in BCD. 59 wraps to 00 and carries into the next field.
- R6: With mode_12h low, hours count 00 to 23 in BCD, and the step from 23 to 00 is a day event.
- R7: With mode_12h high, hour bit 5 is the PM flag and bits 4:0 are a BCD hour from 01 to 12. The sequence is 12, 01 to 11, and the step from 11 to 12 flips PM. The step from 11 PM to 12 AM is a day event.
- R8: Each day event steps the day of week from 1 to 7 and then back to 1, independently of the date.
- R9: April, June, September and November have 30 days, and the other months except February have 31. The last date wraps to 01 and advances the month. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R10: February has 29 days when the year value is divisible by four (00, 04, ..., 96) and 28 days otherwise.
- R11: With wr_en high, address 0 to 6 selects seconds, minutes, hours, day of week, date, month or year. The written value shows after the next edge and replaces any advance of that field in the same cycle. A written field passes no carry onward. Address 7 is ignored.
- R12: A write to the seconds field clears the prescaler. The next event needs a full XTAL_DIV ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | High lets the prescaler and counters run |
| src_line | input | 1 | High selects the mains tick source |
| line_50 | input | 1 | High selects 50 ticks per second, low selects 60 |
| xtal_tick | input | 1 | Crystal-derived tick pulse |
| line_tick | input | 1 | Mains-derived tick pulse |
| mode_12h | input | 1 | High selects 12-hour encoding |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field select for writes |
| wr_data | input | 8 | BCD write value |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD (bit 5 is PM in 12-hour mode) |
| dow_o | output | 8 | Day of week, 1 to 7 |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year 00 to 99, BCD |

## Verification
The assertions assume that the host writes only valid BCD values that fit each field and the selected hour encoding. They also assume that mode_12h changes only together with a rewrite of the hours field, and that the tick source is switched only right after a seconds write. The stimulus builds every loaded value from legal integers, which are biased toward the last second of a minute, hour, day, month and year. It always follows a mode or source change with a full reload.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int ADDR_W     = 3;

  typedef enum logic [ADDR_W-1:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DOW   = 3'd3,
    FLD_DATE  = 3'd4,
    FLD_MONTH = 3'd5,
    FLD_YEAR  = 3'd6
  } fld_e;

  // two-digit BCD increment (caller handles field wrap)
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // year divisible by four: 10 is 2 mod 4, so check (2*tens + ones) mod 4
  function automatic logic bcd_leap(input logic [7:0] y);
    logic [4:0] t;
    t = {y[7:4], 1'b0} + {1'b0, y[3:0]};
    return t[1:0] == 2'b00;
  endfunction

  // last day of the month in BCD
  function automatic logic [7:0] bcd_month_len(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int XTAL_DIV = 32,
  parameter int LINE_HI  = 60,
  parameter int LINE_LO  = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic src_line,
  input  logic line_lo,
  input  logic xtal_tick,
  input  logic line_tick,
  input  logic clear,
  output logic sec_evt
);
  localparam int MAXD = (XTAL_DIV > LINE_HI) ? ((XTAL_DIV > LINE_LO) ? XTAL_DIV : LINE_LO)
                                             : ((LINE_HI > LINE_LO) ? LINE_HI : LINE_LO);
  localparam int CW = $clog2(MAXD);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          tick;
  logic          at_last;

  always_comb begin
    if (src_line) last = line_lo ? CW'(LINE_LO - 1) : CW'(LINE_HI - 1);
    else          last = CW'(XTAL_DIV - 1);
  end

  assign tick    = src_line ? line_tick : xtal_tick;
  assign at_last = (cnt >= last);
  assign sec_evt = run && !clear && tick && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || clear)  cnt <= '0;
    else if (tick)           cnt <= at_last ? '0 : cnt + CW'(1);
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
  assert_no_evt_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sec_evt);
  assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));
  assert_src_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_line && !line_tick) |-> !sec_evt);
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_evt,
  input  logic       mode_12h,
  input  logic       wr_sec,
  input  logic       wr_min,
  input  logic       wr_hour,
  input  logic [7:0] wr_data,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic       day_evt
);
  logic       sec_wrap, min_wrap;
  logic [7:0] sec_nx, min_nx, hour_nx;
  logic [4:0] h5, h5_inc;
  logic       pm;

  assign sec_wrap = sec_evt && (sec == 8'h59);
  assign min_wrap = sec_wrap && (min == 8'h59) && !wr_min;
  assign sec_nx   = (sec == 8'h59) ? 8'h00 : bcd_inc(sec);
  assign min_nx   = (min == 8'h59) ? 8'h00 : bcd_inc(min);

  assign h5     = hour[4:0];
  assign pm     = hour[5];
  assign h5_inc = (h5[3:0] >= 4'd9) ? 5'h10 : {h5[4], h5[3:0] + 4'd1};

  always_comb begin
    if (mode_12h) begin
      if (h5 == 5'h11)      hour_nx = {2'b00, ~pm, 5'h12};
      else if (h5 == 5'h12) hour_nx = {2'b00, pm, 5'h01};
      else                  hour_nx = {2'b00, pm, h5_inc};
      day_evt = min_wrap && !wr_hour && (h5 == 5'h11) && pm;
    end else begin
      hour_nx = (hour == 8'h23) ? 8'h00 : bcd_inc(hour);
      day_evt = min_wrap && !wr_hour && (hour == 8'h23);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec  <= 8'h00;
      min  <= 8'h00;
      hour <= 8'h00;
    end else begin
      if (wr_sec)        sec <= wr_data;
      else if (sec_evt)  sec <= sec_nx;
      if (wr_min)        min <= wr_data;
      else if (sec_wrap) min <= min_nx;
      if (wr_hour)       hour <= wr_data;
      else if (min_wrap) hour <= hour_nx;
    end
  end

  assert_sec_roll_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt && !wr_sec && sec == 8'h59) |=> (sec == 8'h00));
  assert_min_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_min && !sec_wrap) |=> $stable(min));
  assert_day24_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_12h && min_wrap && !wr_hour && hour == 8'h23) |=> (hour == 8'h00));
  assert_pm_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_12h && min_wrap && !wr_hour && h5 == 5'h11) |=> (hour[5] != $past(hour[5])));
  assert_hour_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hour && !min_wrap) |=> $stable(hour));
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_evt,
  input  logic       wr_dow,
  input  logic       wr_date,
  input  logic       wr_month,
  input  logic       wr_year,
  input  logic [7:0] wr_data,
  output logic [7:0] dow,
  output logic [7:0] date,
  output logic [7:0] month,
  output logic [7:0] year
);
  logic [7:0] dim;
  logic       date_wrap, month_wrap;

  assign dim        = bcd_month_len(month, year);
  assign date_wrap  = day_evt && !wr_date && (date >= dim);
  assign month_wrap = date_wrap && !wr_month && (month >= 8'h12);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dow   <= 8'h01;
      date  <= 8'h01;
      month <= 8'h01;
      year  <= 8'h00;
    end else begin
      if (wr_dow)          dow <= wr_data;
      else if (day_evt)    dow <= (dow >= 8'h07) ? 8'h01 : dow + 8'h01;
      if (wr_date)         date <= wr_data;
      else if (day_evt)    date <= date_wrap ? 8'h01 : bcd_inc(date);
      if (wr_month)        month <= wr_data;
      else if (date_wrap)  month <= (month >= 8'h12) ? 8'h01 : bcd_inc(month);
      if (wr_year)         year <= wr_data;
      else if (month_wrap) year <= (year == 8'h99) ? 8'h00 : bcd_inc(year);
    end
  end

  assert_dow_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (day_evt && !wr_dow && dow == 8'h07) |=> (dow == 8'h01));
  assert_month_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_month && !date_wrap) |=> $stable(month));
  assert_leap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (day_evt && !wr_date && !wr_month && !wr_year && month == 8'h02 && date == 8'h28
     && bcd_leap(year)) |=> (date == 8'h29 && month == 8'h02));
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_pkg::*;
#(
  parameter int XTAL_DIV = 32,
  parameter int LINE_HI  = 60,
  parameter int LINE_LO  = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              src_line,
  input  logic              line_50,
  input  logic              xtal_tick,
  input  logic              line_tick,
  input  logic              mode_12h,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        sec_o,
  output logic [7:0]        min_o,
  output logic [7:0]        hour_o,
  output logic [7:0]        dow_o,
  output logic [7:0]        date_o,
  output logic [7:0]        month_o,
  output logic [7:0]        year_o
);
  logic [NUM_FIELDS-1:0] wr_hit;
  logic                  sec_evt;
  logic                  day_evt;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dec
    assign wr_hit[i] = wr_en && (wr_addr == ADDR_W'(i));
  end

  rtc_prescaler #(
    .XTAL_DIV(XTAL_DIV), .LINE_HI(LINE_HI), .LINE_LO(LINE_LO)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .src_line(src_line), .line_lo(line_50),
    .xtal_tick(xtal_tick), .line_tick(line_tick), .clear(wr_hit[FLD_SEC]),
    .sec_evt(sec_evt)
  );

  rtc_time_chain u_time (
    .clk(clk), .rst_n(rst_n), .sec_evt(sec_evt), .mode_12h(mode_12h),
    .wr_sec(wr_hit[FLD_SEC]), .wr_min(wr_hit[FLD_MIN]), .wr_hour(wr_hit[FLD_HOUR]),
    .wr_data(wr_data), .sec(sec_o), .min(min_o), .hour(hour_o), .day_evt(day_evt)
  );

  rtc_date_chain u_date (
    .clk(clk), .rst_n(rst_n), .day_evt(day_evt),
    .wr_dow(wr_hit[FLD_DOW]), .wr_date(wr_hit[FLD_DATE]),
    .wr_month(wr_hit[FLD_MONTH]), .wr_year(wr_hit[FLD_YEAR]),
    .wr_data(wr_data), .dow(dow_o), .date(date_o), .month(month_o), .year(year_o)
  );

  assert_wr_year_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == FLD_YEAR) |=> (year_o == $past(wr_data)));
  assert_wr_sec_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == FLD_SEC) |=> (sec_o == $past(wr_data)));
  assert_day_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    day_evt |-> sec_evt);
endmodule

// File: tb/rtc_bcd_calendar_tb.sv
module rtc_bcd_calendar_tb;
  localparam int DIV = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b1, src_line = 1'b0, line_50 = 1'b0;
  logic xt = 1'b0, lt = 1'b0, m12 = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  int s, m, h, dw, dt, mo, yr;

  always #2 clk = ~clk;

  rtc_bcd_calendar u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .src_line(src_line), .line_50(line_50),
    .xtal_tick(xt), .line_tick(lt), .mode_12h(m12),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o)
  );

  function automatic logic [7:0] tobcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int mdays(int mon, int y);
    if (mon == 2) return (y % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hour_enc(int hh, logic twelve);
    int k;
    if (!twelve) return tobcd(hh);
    k = (hh % 12 == 0) ? 12 : hh % 12;
    return {2'b00, (hh >= 12), 1'(k / 10), 4'(k % 10)};
  endfunction

  task automatic model_sec();
    s++;
    if (s == 60) begin
      s = 0; m++;
      if (m == 60) begin
        m = 0; h++;
        if (h == 24) begin
          h = 0; dw = (dw % 7) + 1; dt++;
          if (dt > mdays(mo, yr)) begin
            dt = 1; mo++;
            if (mo == 13) begin mo = 1; yr = (yr + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic check(string rq);
    logic [55:0] act, exp;
    act = {sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o};
    exp = {tobcd(s), tobcd(m), hour_enc(h, m12), tobcd(dw), tobcd(dt), tobcd(mo), tobcd(yr)};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic load(int ns, int nm, int nh, int ndw, int ndt, int nmo, int nyr);
    s = ns; m = nm; h = nh; dw = ndw; dt = ndt; mo = nmo; yr = nyr;
    wr(3'd1, tobcd(m)); wr(3'd2, hour_enc(h, m12)); wr(3'd3, tobcd(dw));
    wr(3'd4, tobcd(dt)); wr(3'd5, tobcd(mo)); wr(3'd6, tobcd(yr));
    wr(3'd0, tobcd(s));
  endtask

  task automatic xpulses(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); xt = 1'b1; end
    @(negedge clk); xt = 1'b0;
  endtask

  task automatic lpulses(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); lt = 1'b1; end
    @(negedge clk); lt = 1'b0;
  endtask

  task automatic run_secs(int n, string rq);
    for (int i = 0; i < n; i++) begin
      xpulses(DIV); model_sec(); check(rq);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    s = 0; m = 0; h = 0; dw = 1; dt = 1; mo = 1; yr = 0;
    check("R1 reset");

    // R2: crystal path, one event per DIV ticks
    xpulses(DIV - 1); check("R2 before event");
    xpulses(1); model_sec(); check("R2 event");
    run_secs(3, "R2 steady");

    // R12: seconds write clears prescaler
    xpulses(20);
    wr(3'd0, 8'h10); s = 10;
    xpulses(DIV - 1); check("R12 no early event");
    xpulses(1); model_sec(); check("R12 full second");

    // R4: run low holds everything
    xpulses(10);
    @(negedge clk); run = 1'b0;
    xpulses(3 * DIV); check("R4 stopped");
    @(negedge clk); run = 1'b1;
    xpulses(DIV - 1); check("R4 restart partial");
    xpulses(1); model_sec(); check("R4 restart event");

    // R3: line source, xtal ignored, 50 and 60 ticks
    wr(3'd0, 8'h20); s = 20;
    @(negedge clk); src_line = 1'b1; line_50 = 1'b1;
    xpulses(2 * DIV); check("R3 xtal ignored");
    lpulses(49); check("R3 50 partial");
    lpulses(1); model_sec(); check("R3 50 event");
    @(negedge clk); line_50 = 1'b0;
    wr(3'd0, 8'h30); s = 30;
    lpulses(59); check("R3 60 partial");
    lpulses(1); model_sec(); check("R3 60 event");
    @(negedge clk); src_line = 1'b0;
    wr(3'd0, 8'h00); s = 0;

    // R11: unused address ignored
    wr(3'd7, 8'h55); check("R11 addr7 ignored");

    // R11: write beats advance in same cycle, no carry from written field
    load(59, 59, 5, 2, 10, 6, 30);
    xpulses(DIV - 1);
    @(negedge clk); xt = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h30;
    @(negedge clk); xt = 1'b0; wr_en = 1'b0;
    s = 0; m = 30; check("R11 write overrides carry");

    // R5 R6 R8 R9: 24-hour rollovers
    load(59, 59, 23, 7, 30, 4, 15); run_secs(1, "R6 R8 R9 april end");
    load(58, 59, 23, 3, 31, 12, 99); run_secs(2, "R9 year wrap");
    load(55, 59, 12, 4, 31, 1, 50); run_secs(6, "R5 minute carry");
    // R10 leap cases
    load(59, 59, 23, 1, 28, 2, 24); run_secs(1, "R10 leap 24");
    load(59, 59, 23, 1, 28, 2, 0);  run_secs(1, "R10 leap 00");
    load(59, 59, 23, 1, 28, 2, 23); run_secs(1, "R10 common 23");
    load(59, 59, 23, 1, 29, 2, 96); run_secs(1, "R10 leap end 96");

    // R7: 12-hour mode
    @(negedge clk); m12 = 1'b1;
    load(59, 59, 11, 5, 12, 8, 40); run_secs(1, "R7 11am to 12pm");
    load(59, 59, 12, 5, 12, 8, 40); run_secs(1, "R7 12pm to 1pm");
    load(59, 59, 23, 7, 31, 8, 40); run_secs(1, "R7 R8 11pm to 12am");
    load(59, 59, 0, 2, 3, 3, 41);   run_secs(1, "R7 12am to 1am");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int nmo, nyr, ndt, nh, nm;
      @(negedge clk); m12 = 1'($urandom % 2);
      nmo = 1 + int'($urandom % 12);
      nyr = int'($urandom % 100);
      ndt = ($urandom % 2 == 0) ? mdays(nmo, nyr) : 1 + int'($urandom % mdays(nmo, nyr));
      nh  = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
      nm  = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
      load(50 + int'($urandom % 10), nm, nh, 1 + int'($urandom % 7), ndt, nmo, nyr);
      run_secs(1 + int'($urandom % 12), "R5 R6 R7 R9 R10 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule